// File: doc/BRIEF.md
# Configuration Register Bridge Between Unrelated Clocks

This block moves single register accesses from a host-side configuration clock into an independent core clock and brings the result back. Every access is one 32-bit word at a 16-bit address, and each is handled on its own, with no bursts. The host side has a valid/ready request port and a one-cycle response strobe. The core side has a plain register request port with valid/ready, plus a response input from the register file behind the bridge.

The crossing is a toggle handshake. The host captures the request and flips a request toggle, which reaches the core through a two-flop synchronizer. The core presents the held payload and waits for the register file to answer. It then registers the answer and flips an acknowledge toggle, which travels back through a second synchronizer. Only one access is in flight at a time. Host ready stays low from acceptance until the acknowledge arrives, so the payload never moves while the other clock samples it.

Reads always return data. A write returns a completion strobe only when the host marks it non-posted. A posted write completes silently, and the only sign that it is done is host ready rising again. Each domain has its own active-low asynchronous reset, and each reset clears that domain's toggle and handshake state.

Top module: `cfgx_bridge`

## Requirements
- R1: After reset, h_req_ready_o is 1, h_rsp_valid_o is 0 and c_req_valid_o is 0.
- R2: A read (h_req_write_i=0) returns, on h_rsp_valid_o, the 32-bit word the core returned for that address, with h_rsp_write_o=0 and h_rsp_err_o equal to the core's error flag.
- R3: A posted write (h_req_write_i=1, h_req_np_i=0) reaches the core with its address and data, produces no h_rsp_valid_o, and h_req_ready_o returns to 1 once the core has answered.
- R4: A non-posted write (h_req_write_i=1, h_req_np_i=1) produces one h_rsp_valid_o with h_rsp_write_o=1.
- R5: Only one access is in flight. h_req_ready_o is 0 from the cycle after acceptance until the response returns. h_req_valid_i asserted while ready is 0 is ignored, so the core sees exactly one request per accepted access.
- R6: Once raised, c_req_valid_o and the core payload (c_req_write_o, c_req_addr_o, c_req_wdata_o) stay unchanged until a cycle with c_req_ready_i=1. c_req_valid_o drops in the cycle after that.
- R7: h_rsp_valid_o is a single-cycle strobe, and it rises in the same cycle that h_req_ready_o returns to 1.
- R8: R2 to R7 hold whether the core clock is slower or faster than the host clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_h_i | input | 1 | Host configuration clock |
| rst_h_ni | input | 1 | Host-domain async reset, active low |
| clk_c_i | input | 1 | Core clock |
| rst_c_ni | input | 1 | Core-domain async reset, active low |
| h_req_valid_i | input | 1 | Host request valid |
| h_req_ready_o | output | 1 | Bridge idle and able to accept |
| h_req_write_i | input | 1 | 1 = write, 0 = read |
| h_req_np_i | input | 1 | Write wants a completion strobe |
| h_req_addr_i | input | 16 | Register address |
| h_req_wdata_i | input | 32 | Write data |
| h_rsp_valid_o | output | 1 | One-cycle response strobe |
| h_rsp_write_o | output | 1 | Response is a write completion |
| h_rsp_rdata_o | output | 32 | Read data, 0 for writes |
| h_rsp_err_o | output | 1 | Error flag from the core |
| c_req_valid_o | output | 1 | Core request valid |
| c_req_ready_i | input | 1 | Core accepts request |
| c_req_write_o | output | 1 | Core request is a write |
| c_req_addr_o | output | 16 | Core request address |
| c_req_wdata_o | output | 32 | Core request write data |
| c_rsp_valid_i | input | 1 | Core response valid |
| c_rsp_rdata_i | input | 32 | Core read data |
| c_rsp_err_i | input | 1 | Core error flag |

## Verification
A lost toggle edge leaves h_req_ready_o stuck low. This shows up as a per-access timeout a few hundred host cycles after acceptance. A doubled or spurious toggle appears on the core port as an extra request, which the final core-side request count exposes. A payload that shifts while the core stalls, or read data latched from the wrong cycle, gives a data miscompare on the very next access. A wrong posted/non-posted decision shows up as a missing or extra strobe in the cycle where ready rises.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    C_IDLE    = 2'd0,
    C_PRESENT = 2'd1,
    C_WAIT    = 2'd2
  } core_st_e;
endpackage

// File: rtl/cfgx_sync.sv
module cfgx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/cfgx_host_side.sv
module cfgx_host_side #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic          req_np_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_write_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_err_o,
  output logic          req_tgl_o,
  output logic          hold_write_o,
  output logic [AW-1:0] hold_addr_o,
  output logic [DW-1:0] hold_wdata_o,
  input  logic          ack_tgl_i,
  input  logic [DW-1:0] core_rdata_i,
  input  logic          core_err_i
);
  logic          busy_q, req_tgl_q, ack_seen_q, np_q;
  logic          ack_sync, ack_evt, accept;
  logic          rsp_valid_q, rsp_write_q, rsp_err_q;
  logic [DW-1:0] rsp_rdata_q;

  cfgx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_tgl_i), .q_o(ack_sync)
  );

  assign accept  = req_valid_i && !busy_q;
  assign ack_evt = busy_q && (ack_sync != ack_seen_q);

  // payload frozen while busy: the core domain samples it directly
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_write_o <= 1'b0;
      hold_addr_o  <= '0;
      hold_wdata_o <= '0;
      np_q         <= 1'b0;
    end else if (accept) begin
      hold_write_o <= req_write_i;
      hold_addr_o  <= req_addr_i;
      hold_wdata_o <= req_wdata_i;
      np_q         <= req_np_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      req_tgl_q  <= 1'b0;
      ack_seen_q <= 1'b0;
    end else begin
      if (accept) begin
        busy_q    <= 1'b1;
        req_tgl_q <= ~req_tgl_q;
      end else if (ack_evt) begin
        busy_q     <= 1'b0;
        ack_seen_q <= ack_sync;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_write_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_err_q   <= 1'b0;
    end else if (ack_evt) begin
      rsp_valid_q <= !hold_write_o || np_q;
      rsp_write_q <= hold_write_o;
      rsp_rdata_q <= hold_write_o ? '0 : core_rdata_i;
      rsp_err_q   <= core_err_i;
    end else begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign req_ready_o = !busy_q;
  assign req_tgl_o   = req_tgl_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_write_o = rsp_write_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_err_o   = rsp_err_q;

  a_r5_ready_low_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r5_payload_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> ($stable(hold_addr_o) && $stable(hold_wdata_o)));

  a_r7_rsp_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r7_rsp_with_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (req_ready_o && $past(!req_ready_o)));
endmodule

// File: rtl/cfgx_core_side.sv
module cfgx_core_side
  import cfgx_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_tgl_i,
  input  logic          hold_write_i,
  input  logic [AW-1:0] hold_addr_i,
  input  logic [DW-1:0] hold_wdata_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic          req_write_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_rdata_i,
  input  logic          rsp_err_i,
  output logic          ack_tgl_o,
  output logic [DW-1:0] rdata_o,
  output logic          err_o
);
  core_st_e      st_q;
  logic          req_sync, req_seen_q, ack_tgl_q, err_q;
  logic [DW-1:0] rdata_q;

  cfgx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_tgl_i), .q_o(req_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= C_IDLE;
      req_seen_q <= 1'b0;
      ack_tgl_q  <= 1'b0;
      rdata_q    <= '0;
      err_q      <= 1'b0;
    end else begin
      unique case (st_q)
        C_IDLE: if (req_sync != req_seen_q) begin
          req_seen_q <= req_sync;
          st_q       <= C_PRESENT;
        end
        C_PRESENT: if (req_ready_i) st_q <= C_WAIT;
        C_WAIT: if (rsp_valid_i) begin
          rdata_q   <= rsp_rdata_i;
          err_q     <= rsp_err_i;
          ack_tgl_q <= ~ack_tgl_q;
          st_q      <= C_IDLE;
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  assign req_valid_o = (st_q == C_PRESENT);
  assign req_write_o = hold_write_i;
  assign req_addr_o  = hold_addr_i;
  assign req_wdata_o = hold_wdata_i;
  assign ack_tgl_o   = ack_tgl_q;
  assign rdata_o     = rdata_q;
  assign err_o       = err_q;

  a_r6_valid_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_wdata_o)
                                       && $stable(req_write_o)));

  a_r6_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> !req_valid_o);

  a_r5_ack_needs_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_tgl_o != $past(ack_tgl_o)) |-> $past(rsp_valid_i));
endmodule

// File: rtl/cfgx_bridge.sv
module cfgx_bridge #(
  parameter int unsigned AW = cfgx_pkg::ADDR_W,
  parameter int unsigned DW = cfgx_pkg::DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_h_i,
  input  logic          rst_h_ni,
  input  logic          clk_c_i,
  input  logic          rst_c_ni,
  input  logic          h_req_valid_i,
  output logic          h_req_ready_o,
  input  logic          h_req_write_i,
  input  logic          h_req_np_i,
  input  logic [AW-1:0] h_req_addr_i,
  input  logic [DW-1:0] h_req_wdata_i,
  output logic          h_rsp_valid_o,
  output logic          h_rsp_write_o,
  output logic [DW-1:0] h_rsp_rdata_o,
  output logic          h_rsp_err_o,
  output logic          c_req_valid_o,
  input  logic          c_req_ready_i,
  output logic          c_req_write_o,
  output logic [AW-1:0] c_req_addr_o,
  output logic [DW-1:0] c_req_wdata_o,
  input  logic          c_rsp_valid_i,
  input  logic [DW-1:0] c_rsp_rdata_i,
  input  logic          c_rsp_err_i
);
  logic          req_tgl, ack_tgl, hold_write, core_err;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_wdata, core_rdata;

  cfgx_host_side #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_host (
    .clk_i(clk_h_i), .rst_ni(rst_h_ni),
    .req_valid_i(h_req_valid_i), .req_ready_o(h_req_ready_o),
    .req_write_i(h_req_write_i), .req_np_i(h_req_np_i),
    .req_addr_i(h_req_addr_i), .req_wdata_i(h_req_wdata_i),
    .rsp_valid_o(h_rsp_valid_o), .rsp_write_o(h_rsp_write_o),
    .rsp_rdata_o(h_rsp_rdata_o), .rsp_err_o(h_rsp_err_o),
    .req_tgl_o(req_tgl), .hold_write_o(hold_write),
    .hold_addr_o(hold_addr), .hold_wdata_o(hold_wdata),
    .ack_tgl_i(ack_tgl), .core_rdata_i(core_rdata), .core_err_i(core_err)
  );

  cfgx_core_side #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk_i(clk_c_i), .rst_ni(rst_c_ni),
    .req_tgl_i(req_tgl), .hold_write_i(hold_write),
    .hold_addr_i(hold_addr), .hold_wdata_i(hold_wdata),
    .req_valid_o(c_req_valid_o), .req_ready_i(c_req_ready_i),
    .req_write_o(c_req_write_o), .req_addr_o(c_req_addr_o),
    .req_wdata_o(c_req_wdata_o),
    .rsp_valid_i(c_rsp_valid_i), .rsp_rdata_i(c_rsp_rdata_i),
    .rsp_err_i(c_rsp_err_i),
    .ack_tgl_o(ack_tgl), .rdata_o(core_rdata), .err_o(core_err)
  );
endmodule

// File: tb/cfgx_bridge_tb.sv
`timescale 1ns/1ps
module cfgx_bridge_tb;
  logic clk_h = 0, clk_c = 0, rst_h_n = 0, rst_c_n = 0;
  realtime c_half = 6.5;
  always #4 clk_h = ~clk_h;
  always #(c_half) clk_c = ~clk_c;

  logic        h_req_valid = 0, h_req_ready, h_req_write = 0, h_req_np = 0;
  logic [15:0] h_req_addr = 0;
  logic [31:0] h_req_wdata = 0;
  logic        h_rsp_valid, h_rsp_write, h_rsp_err;
  logic [31:0] h_rsp_rdata;
  logic        c_req_valid, c_req_ready = 0, c_req_write;
  logic [15:0] c_req_addr;
  logic [31:0] c_req_wdata;
  logic        c_rsp_valid = 0, c_rsp_err = 0;
  logic [31:0] c_rsp_rdata = 0;

  cfgx_bridge u_dut (
    .clk_h_i(clk_h), .rst_h_ni(rst_h_n), .clk_c_i(clk_c), .rst_c_ni(rst_c_n),
    .h_req_valid_i(h_req_valid), .h_req_ready_o(h_req_ready),
    .h_req_write_i(h_req_write), .h_req_np_i(h_req_np),
    .h_req_addr_i(h_req_addr), .h_req_wdata_i(h_req_wdata),
    .h_rsp_valid_o(h_rsp_valid), .h_rsp_write_o(h_rsp_write),
    .h_rsp_rdata_o(h_rsp_rdata), .h_rsp_err_o(h_rsp_err),
    .c_req_valid_o(c_req_valid), .c_req_ready_i(c_req_ready),
    .c_req_write_o(c_req_write), .c_req_addr_o(c_req_addr),
    .c_req_wdata_o(c_req_wdata),
    .c_rsp_valid_i(c_rsp_valid), .c_rsp_rdata_i(c_rsp_rdata), .c_rsp_err_i(c_rsp_err)
  );

  int n_vec = 0, n_bad = 0;
  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // core-side register file model
  logic [31:0] regs [16];
  logic [31:0] shadow [16];
  int          stall_cfg = 0, stall_cnt = 0, core_accepts = 0;
  bit          resp_due = 0, seen_first = 0, last_wr = 0;
  logic [15:0] cap_addr, last_addr;
  logic [31:0] cap_wdata, last_wdata;
  logic        cap_write;

  initial for (int i = 0; i < 16; i++) begin regs[i] = 0; shadow[i] = 0; end

  always @(negedge clk_c) begin
    if (c_rsp_valid) c_rsp_valid <= 0;
    if (resp_due) begin
      resp_due    <= 0;
      c_rsp_valid <= 1;
      c_rsp_rdata <= last_wr ? 32'h0 : regs[last_addr[3:0]];
      c_rsp_err   <= last_addr[15];
    end
    if (c_req_ready) begin
      c_req_ready <= 0;
      resp_due    <= 1;
      seen_first  <= 0;
      core_accepts++;
      last_wr    <= c_req_write;
      last_addr  <= c_req_addr;
      last_wdata <= c_req_wdata;
      if (c_req_write) regs[c_req_addr[3:0]] <= c_req_wdata;
    end else if (c_req_valid) begin
      if (!seen_first) begin
        seen_first <= 1;
        cap_addr   <= c_req_addr;
        cap_wdata  <= c_req_wdata;
        cap_write  <= c_req_write;
      end else begin
        // R6: payload stable while the core stalls
        check(c_req_addr == cap_addr && c_req_wdata == cap_wdata && c_req_write == cap_write,
              "R6 payload held", {c_req_addr, c_req_wdata}, {cap_addr, cap_wdata});
      end
      if (stall_cnt < stall_cfg) stall_cnt++;
      else begin
        stall_cnt   <= 0;
        c_req_ready <= 1;
      end
    end
  end

  // R6: valid drops the core cycle after acceptance
  logic acc_prev = 0;
  always @(negedge clk_c) begin
    if (acc_prev) check(!c_req_valid, "R6 valid drops", c_req_valid, 0);
    acc_prev <= c_req_valid && c_req_ready;
  end

  int host_txns = 0;
  task automatic txn(input bit wr, input bit np, input logic [15:0] a, input logic [31:0] d,
                     input bit hog, input string tag);
    int t;
    bit exp_rsp;
    logic [31:0] exp_d;
    exp_rsp = !wr || np;
    exp_d   = wr ? 32'h0 : shadow[a[3:0]];
    t = 0;
    while (!h_req_ready && t < 500) begin @(negedge clk_h); t++; end
    h_req_valid = 1; h_req_write = wr; h_req_np = np; h_req_addr = a; h_req_wdata = d;
    @(negedge clk_h);
    host_txns++;
    check(!h_req_ready, "R5 ready low after accept", h_req_ready, 0);
    if (hog) begin
      h_req_addr = ~a; h_req_wdata = ~d; h_req_write = ~wr;
    end else h_req_valid = 0;
    t = 0;
    while (!h_req_ready && t < 500) begin
      check(!h_rsp_valid, "R7 no strobe while busy", h_rsp_valid, 0);
      @(negedge clk_h); t++;
    end
    h_req_valid = 0;
    check(t < 500, {tag, " completion timeout"}, t, 500);
    check(h_rsp_valid == exp_rsp, {tag, " strobe with ready"}, h_rsp_valid, exp_rsp);
    if (exp_rsp) begin
      check(h_rsp_write == wr, {tag, " rsp kind"}, h_rsp_write, wr);
      check(h_rsp_rdata == exp_d, {tag, " rsp data"}, h_rsp_rdata, exp_d);
      check(h_rsp_err == a[15], {tag, " rsp err"}, h_rsp_err, a[15]);
    end
    if (wr) shadow[a[3:0]] = d;
    @(negedge clk_h);
    check(!h_rsp_valid, "R7 strobe one cycle", h_rsp_valid, 0);
  endtask

  task automatic sweep(input logic [31:0] seed, input bit hog);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a;
      logic [31:0] d;
      a = {i[0], 7'h0, 4'(i * 3), 4'(i)};
      d = seed ^ (32'(i) * 32'h01010101);
      if (i % 2 == 0) txn(1, 0, a, d, hog, "R3 posted write");
      else            txn(1, 1, a, d, hog, "R4 nonposted write");
    end
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a;
      a = {i[0], 7'h0, 4'(15 - i), 4'(i)};
      txn(0, 0, a, 32'h0, hog, "R2 read");
    end
  endtask

  bit done = 0;
  initial begin
    #50000000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #30 rst_h_n = 1; rst_c_n = 1;
    repeat (3) @(negedge clk_h);
    check(h_req_ready == 1, "R1 ready after reset", h_req_ready, 1);
    check(h_rsp_valid == 0, "R1 no strobe after reset", h_rsp_valid, 0);
    check(c_req_valid == 0, "R1 no core request after reset", c_req_valid, 0);
    // R8: core slower than host
    sweep(32'hA5000000, 0);
    // R8: core faster, with stalls, host holding valid while busy (R5)
    c_half = 1.5; stall_cfg = 3;
    repeat (4) @(negedge clk_h);
    sweep(32'h3C00F00F, 1);
    // R8: core much slower
    c_half = 20.0; stall_cfg = 2;
    repeat (4) @(negedge clk_h);
    sweep(32'h12345678, 0);
    repeat (40) @(negedge clk_h);
    check(core_accepts == host_txns, "R5 one core request per access", core_accepts, host_txns);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule